// File: doc/BRIEF.md
# Rotate-Zoom-Crop Source Address Generator

This block drives the fetch side of an image transform engine. After a start pulse it walks every output pixel of an `IMG_W` x `IMG_H` frame, row by row with the column index moving fastest. For each output position it maps back into the source image under a combined rotation, reciprocal zoom and integer crop offset. It then reports the four integer source pixels that surround the mapped point as linear memory addresses, the 7-bit sub-pixel weights along each axis, and a flag that marks positions whose neighbourhood falls outside the source image.

The rotation arrives as cosine and sine values already scaled by 128, so cos 60° is 64. The zoom arrives as 128 divided by the zoom ratio, so a ×4 zoom is 32. Because the trigonometry is prepared upstream, any angle from 0 to 360 degrees is reachable. A four-stage pipeline yields one address set per clock once it has filled. The last pixel of a frame carries a finish strobe.

The sequencer has three states. `ST_IDLE` waits. A start moves it to `ST_SCAN` and loads the parameters. `ST_SCAN` steps the counters once per clock and moves to `ST_DRAIN` after the last position. `ST_DRAIN` returns to `ST_IDLE` in the clock where the last pixel reaches the output register.

Top module: `rzc_addr_gen`

## Requirements
- R1: While reset is held and right after it, `valid`, `finish` and `out_of_range` are 0.
- R2: A `start` sampled in the idle state yields exactly `IMG_W*IMG_H` results on consecutive clocks. The first result appears with `valid` high 5 rising edges after the start edge (start edge included). Results come in raster order: row 0 first, columns ascending within a row.
- R3: The rotation, zoom and crop inputs are captured at the accepted start. Changes to them while a frame is in progress do not affect that frame's results.
- R4: For output row r and column c, the source column in 7-fraction fixed point is `SX = crop_x*128 + floor(zoom_inv*(rot_cos*c - rot_sin*r)/128)`. The source row is `SY = crop_y*128 + floor(zoom_inv*(rot_sin*c + rot_cos*r)/128)`. `rot_cos` and `rot_sin` are signed two's complement; `zoom_inv`, `crop_x` and `crop_y` are unsigned.
- R5: The top-left neighbour has column `floor(SX/128)` and row `floor(SY/128)`. `frac_col` is `SX mod 128` and `frac_row` is `SY mod 128`, which are the low 7 bits.
- R6: For an in-range result, `addr_tl = row*IMG_W + col`, `addr_tr = addr_tl+1`, `addr_bl = addr_tl+IMG_W` and `addr_br = addr_tl+IMG_W+1`.
- R7: `out_of_range` is 1 exactly when the top-left column or row is negative, the column exceeds `IMG_W-2`, or the row exceeds `IMG_H-2`. When it is 1, all four addresses are 0.
- R8: `finish` is 1 only together with `valid` for the result of row `IMG_H-1`, column `IMG_W-1`, and so once per frame.
- R9: A `start` that arrives while a frame is scanning or draining is ignored. No result beyond the frame's `IMG_W*IMG_H` appears.
- R10: A `start` presented in the clock right after `finish` begins a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a frame when idle |
| rot_cos | input | TRIG_W | Cosine of angle ×128, signed |
| rot_sin | input | TRIG_W | Sine of angle ×128, signed |
| zoom_inv | input | ZOOM_W | 128 / zoom ratio, unsigned |
| crop_x | input | CROP_W | Integer source column offset |
| crop_y | input | CROP_W | Integer source row offset |
| valid | output | 1 | Result strobe |
| finish | output | 1 | Last result of the frame |
| out_of_range | output | 1 | Neighbourhood leaves the source image |
| frac_row | output | 7 | Row interpolation weight |
| frac_col | output | 7 | Column interpolation weight |
| addr_tl | output | ADDR_W | Top-left neighbour address |
| addr_tr | output | ADDR_W | Top-right neighbour address |
| addr_bl | output | ADDR_W | Bottom-left neighbour address |
| addr_br | output | ADDR_W | Bottom-right neighbour address |

## Verification
Every pixel of an 8×6 frame is checked against values the bench computes with 64-bit integer arithmetic. This is done under six transforms:
- The identity transform confirms the raster order and the exact edge where the right and bottom columns go out of range.
- A 90° turn with offsets exercises the sine-only path and negative products.
- ×4 zoom at 60° exercises non-zero fractions.
- 333° exercises a negative sine.
- 180° with ×1.5 zoom exercises the floor of negative values.
- A ×0.64 zoom at 30° exercises scale-down.

One frame is disturbed by parameter changes and repeated starts during both scan and drain. Another frame follows a finish with no gap.

// File: rtl/rzc_pkg.sv
package rzc_pkg;
    localparam int FRAC_BITS = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_DRAIN = 2'd2
    } scan_state_e;
endpackage

// File: rtl/rzc_scan_fsm.sv
module rzc_scan_fsm
    import rzc_pkg::*;
#(
    parameter int IMG_W  = 8,
    parameter int IMG_H  = 6,
    parameter int RC_W   = 3,
    parameter int TRIG_W = 9,
    parameter int ZOOM_W = 9,
    parameter int CROP_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     pipe_done,
    input  logic signed [TRIG_W-1:0] cos_in,
    input  logic signed [TRIG_W-1:0] sin_in,
    input  logic        [ZOOM_W-1:0] zf_in,
    input  logic        [CROP_W-1:0] xs_in,
    input  logic        [CROP_W-1:0] ys_in,
    output logic                     pix_valid,
    output logic                     pix_last,
    output logic        [RC_W-1:0]   row_o,
    output logic        [RC_W-1:0]   col_o,
    output logic signed [TRIG_W-1:0] cos_o,
    output logic signed [TRIG_W-1:0] sin_o,
    output logic        [ZOOM_W-1:0] zf_o,
    output logic        [CROP_W-1:0] xs_o,
    output logic        [CROP_W-1:0] ys_o
);
    localparam logic [RC_W-1:0] LAST_COL = RC_W'(IMG_W - 1);
    localparam logic [RC_W-1:0] LAST_ROW = RC_W'(IMG_H - 1);

    scan_state_e state_q, state_d;
    logic        load_params;
    logic [RC_W-1:0] row_q, col_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and strobes
    always_comb begin
        state_d     = state_q;
        load_params = 1'b0;
        pix_valid   = (state_q == ST_SCAN);
        pix_last    = pix_valid && (row_q == LAST_ROW) && (col_q == LAST_COL);
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d     = ST_SCAN;
                    load_params = 1'b1;
                end
            end
            ST_SCAN: begin
                if (pix_last) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (pipe_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // raster counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (load_params) begin
            row_q <= '0;
            col_q <= '0;
        end else if (pix_valid) begin
            if (col_q == LAST_COL) begin
                col_q <= '0;
                row_q <= row_q + RC_W'(1);
            end else begin
                col_q <= col_q + RC_W'(1);
            end
        end
    end

    // parameter capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cos_o <= '0;
            sin_o <= '0;
            zf_o  <= '0;
            xs_o  <= '0;
            ys_o  <= '0;
        end else if (load_params) begin
            cos_o <= cos_in;
            sin_o <= sin_in;
            zf_o  <= zf_in;
            xs_o  <= xs_in;
            ys_o  <= ys_in;
        end
    end

    assign row_o = row_q;
    assign col_o = col_q;

    // R2: raster stepping, column fastest
    p_scan_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_last) |=> pix_valid &&
            (((col_q == $past(col_q) + RC_W'(1)) && (row_q == $past(row_q))) ||
             ((col_q == '0) && (row_q == $past(row_q) + RC_W'(1)))));

    // R3: captured parameters hold while a frame is in flight
    p_hold_params_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(cos_o) && $stable(sin_o) &&
            $stable(zf_o) && $stable(xs_o) && $stable(ys_o)));

    // R9: a start during the scan neither stops nor restarts it
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_last && start) |=> (pix_valid && !((row_q == '0) && (col_q == '0))));
endmodule

// File: rtl/rzc_src_coord.sv
module rzc_src_coord
    import rzc_pkg::*;
#(
    parameter int RC_W   = 3,
    parameter int TRIG_W = 9,
    parameter int ZOOM_W = 9,
    parameter int CROP_W = 8,
    parameter int S_W    = 26
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_last,
    input  logic        [RC_W-1:0]   row_i,
    input  logic        [RC_W-1:0]   col_i,
    input  logic signed [TRIG_W-1:0] cos_i,
    input  logic signed [TRIG_W-1:0] sin_i,
    input  logic        [ZOOM_W-1:0] zf_i,
    input  logic        [CROP_W-1:0] xs_i,
    input  logic        [CROP_W-1:0] ys_i,
    output logic                     out_valid,
    output logic                     out_last,
    output logic signed [S_W-1:0]    sx_o,
    output logic signed [S_W-1:0]    sy_o,
    output logic                     pipe_done
);
    localparam int IDX_W = RC_W + 1;
    localparam int P1_W  = TRIG_W + IDX_W;
    localparam int D_W   = P1_W + 1;
    localparam int Z_W   = ZOOM_W + 1;
    localparam int P2_W  = D_W + Z_W;

    logic signed [IDX_W-1:0] r_s, c_s;
    logic signed [Z_W-1:0]   zf_s;
    logic signed [CROP_W:0]  xs_s, ys_s;

    assign r_s  = $signed({1'b0, row_i});
    assign c_s  = $signed({1'b0, col_i});
    assign zf_s = $signed({1'b0, zf_i});
    assign xs_s = $signed({1'b0, xs_i});
    assign ys_s = $signed({1'b0, ys_i});

    logic                   v_a, l_a, v_b, l_b;
    logic signed [D_W-1:0]  dx_a, dy_a;
    logic signed [P2_W-1:0] px_b, py_b;

    // stage A: rotation products
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_a  <= 1'b0;
            l_a  <= 1'b0;
            dx_a <= '0;
            dy_a <= '0;
        end else begin
            v_a  <= in_valid;
            l_a  <= in_last;
            dx_a <= D_W'(P1_W'(cos_i) * P1_W'(c_s)) - D_W'(P1_W'(sin_i) * P1_W'(r_s));
            dy_a <= D_W'(P1_W'(sin_i) * P1_W'(c_s)) + D_W'(P1_W'(cos_i) * P1_W'(r_s));
        end
    end

    // stage B: zoom scaling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_b  <= 1'b0;
            l_b  <= 1'b0;
            px_b <= '0;
            py_b <= '0;
        end else begin
            v_b  <= v_a;
            l_b  <= l_a;
            px_b <= P2_W'(zf_s) * P2_W'(dx_a);
            py_b <= P2_W'(zf_s) * P2_W'(dy_a);
        end
    end

    // stage C: single truncation, then crop offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            sx_o      <= '0;
            sy_o      <= '0;
        end else begin
            out_valid <= v_b;
            out_last  <= l_b;
            sx_o      <= (S_W'(xs_s) <<< FRAC_BITS) + (S_W'(px_b) >>> FRAC_BITS);
            sy_o      <= (S_W'(ys_s) <<< FRAC_BITS) + (S_W'(py_b) >>> FRAC_BITS);
        end
    end

    assign pipe_done = out_valid && out_last;

    // R8: the last marker travels with a valid pixel
    p_last_has_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
endmodule

// File: rtl/rzc_nbr_addr.sv
module rzc_nbr_addr
    import rzc_pkg::*;
#(
    parameter int IMG_W  = 8,
    parameter int IMG_H  = 6,
    parameter int S_W    = 26,
    parameter int ADDR_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          in_last,
    input  logic signed [S_W-1:0]         sx_i,
    input  logic signed [S_W-1:0]         sy_i,
    output logic                          valid_o,
    output logic                          finish_o,
    output logic                          oor_o,
    output logic [FRAC_BITS-1:0]          frac_col_o,
    output logic [FRAC_BITS-1:0]          frac_row_o,
    output logic [3:0][ADDR_W-1:0]        addr_o
);
    localparam logic signed [S_W-1:0] COL_MAX = S_W'(IMG_W - 2);
    localparam logic signed [S_W-1:0] ROW_MAX = S_W'(IMG_H - 2);
    localparam logic signed [S_W-1:0] STRIDE  = S_W'(IMG_W);

    logic signed [S_W-1:0] col_w, row_w, tl_w;
    logic                  oor_w;

    always_comb begin
        col_w = sx_i >>> FRAC_BITS;
        row_w = sy_i >>> FRAC_BITS;
        tl_w  = row_w * STRIDE + col_w;
        oor_w = col_w[S_W-1] || row_w[S_W-1] || (col_w > COL_MAX) || (row_w > ROW_MAX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o    <= 1'b0;
            finish_o   <= 1'b0;
            oor_o      <= 1'b0;
            frac_col_o <= '0;
            frac_row_o <= '0;
        end else begin
            valid_o    <= in_valid;
            finish_o   <= in_valid && in_last;
            oor_o      <= in_valid && oor_w;
            frac_col_o <= sx_i[FRAC_BITS-1:0];
            frac_row_o <= sy_i[FRAC_BITS-1:0];
        end
    end

    // neighbour k: bit 0 steps one column, bit 1 steps one row
    for (genvar k = 0; k < 4; k++) begin : g_nbr
        localparam logic signed [S_W-1:0] OFS = S_W'(((k / 2) * IMG_W) + (k % 2));
        always_ff @(posedge clk) begin
            if (!rst_n)     addr_o[k] <= '0;
            else if (oor_w) addr_o[k] <= '0;
            else            addr_o[k] <= ADDR_W'(tl_w + OFS);
        end
    end

    // R7: out-of-range results carry zero addresses
    p_oor_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        oor_o |-> (addr_o == '0));

    // R8: finish never without valid
    p_fin_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        finish_o |-> valid_o);
endmodule

// File: rtl/rzc_addr_gen.sv
module rzc_addr_gen
    import rzc_pkg::*;
#(
    parameter int IMG_W  = 8,
    parameter int IMG_H  = 6,
    parameter int TRIG_W = 9,
    parameter int ZOOM_W = 9,
    parameter int CROP_W = 8,
    localparam int MAX_DIM = (IMG_W > IMG_H) ? IMG_W : IMG_H,
    localparam int RC_W    = $clog2(MAX_DIM),
    localparam int ADDR_W  = $clog2(IMG_W * IMG_H)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic signed [TRIG_W-1:0] rot_cos,
    input  logic signed [TRIG_W-1:0] rot_sin,
    input  logic        [ZOOM_W-1:0] zoom_inv,
    input  logic        [CROP_W-1:0] crop_x,
    input  logic        [CROP_W-1:0] crop_y,
    output logic                     valid,
    output logic                     finish,
    output logic                     out_of_range,
    output logic [FRAC_BITS-1:0]     frac_row,
    output logic [FRAC_BITS-1:0]     frac_col,
    output logic [ADDR_W-1:0]        addr_tl,
    output logic [ADDR_W-1:0]        addr_tr,
    output logic [ADDR_W-1:0]        addr_bl,
    output logic [ADDR_W-1:0]        addr_br
);
    localparam int P2_W  = TRIG_W + RC_W + 2 + ZOOM_W + 1;
    localparam int OFS_W = CROP_W + FRAC_BITS + 1;
    localparam int S_W   = ((P2_W > OFS_W) ? P2_W : OFS_W) + 2;

    logic                     s_valid, s_last, pipe_done;
    logic [RC_W-1:0]          s_row, s_col;
    logic signed [TRIG_W-1:0] l_cos, l_sin;
    logic [ZOOM_W-1:0]        l_zf;
    logic [CROP_W-1:0]        l_xs, l_ys;
    logic                     c_valid, c_last;
    logic signed [S_W-1:0]    c_sx, c_sy;
    logic [3:0][ADDR_W-1:0]   nbr;

    rzc_scan_fsm #(
        .IMG_W(IMG_W), .IMG_H(IMG_H), .RC_W(RC_W),
        .TRIG_W(TRIG_W), .ZOOM_W(ZOOM_W), .CROP_W(CROP_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .pipe_done(pipe_done),
        .cos_in(rot_cos), .sin_in(rot_sin), .zf_in(zoom_inv),
        .xs_in(crop_x), .ys_in(crop_y),
        .pix_valid(s_valid), .pix_last(s_last), .row_o(s_row), .col_o(s_col),
        .cos_o(l_cos), .sin_o(l_sin), .zf_o(l_zf), .xs_o(l_xs), .ys_o(l_ys)
    );

    rzc_src_coord #(
        .RC_W(RC_W), .TRIG_W(TRIG_W), .ZOOM_W(ZOOM_W), .CROP_W(CROP_W), .S_W(S_W)
    ) u_coord (
        .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_last(s_last),
        .row_i(s_row), .col_i(s_col), .cos_i(l_cos), .sin_i(l_sin),
        .zf_i(l_zf), .xs_i(l_xs), .ys_i(l_ys),
        .out_valid(c_valid), .out_last(c_last), .sx_o(c_sx), .sy_o(c_sy),
        .pipe_done(pipe_done)
    );

    rzc_nbr_addr #(
        .IMG_W(IMG_W), .IMG_H(IMG_H), .S_W(S_W), .ADDR_W(ADDR_W)
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .in_valid(c_valid), .in_last(c_last),
        .sx_i(c_sx), .sy_i(c_sy),
        .valid_o(valid), .finish_o(finish), .oor_o(out_of_range),
        .frac_col_o(frac_col), .frac_row_o(frac_row), .addr_o(nbr)
    );

    assign addr_tl = nbr[0];
    assign addr_tr = nbr[1];
    assign addr_bl = nbr[2];
    assign addr_br = nbr[3];

    // R6: diagonal neighbour sits one row and one column past top-left
    p_br_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !out_of_range) |-> (addr_br == addr_tl + ADDR_W'(IMG_W + 1)));

    // R1: nothing is reported while reset is applied
    p_quiet_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!valid && !finish && !out_of_range));
endmodule

// File: tb/tb_rzc_addr_gen.sv
module tb_rzc_addr_gen;
    localparam int W    = 8;
    localparam int H    = 6;
    localparam int NPIX = W * H;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic signed [8:0] rot_cos = '0;
    logic signed [8:0] rot_sin = '0;
    logic [8:0]        zoom_inv = '0;
    logic [7:0]        crop_x = '0;
    logic [7:0]        crop_y = '0;
    logic              valid, finish, out_of_range;
    logic [6:0]        frac_row, frac_col;
    logic [5:0]        addr_tl, addr_tr, addr_bl, addr_br;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    rzc_addr_gen #(.IMG_W(W), .IMG_H(H)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rot_cos(rot_cos), .rot_sin(rot_sin), .zoom_inv(zoom_inv),
        .crop_x(crop_x), .crop_y(crop_y),
        .valid(valid), .finish(finish), .out_of_range(out_of_range),
        .frac_row(frac_row), .frac_col(frac_col),
        .addr_tl(addr_tl), .addr_tr(addr_tr), .addr_bl(addr_bl), .addr_br(addr_br)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected source point per R4 and R5
    function automatic void model(input int cs, input int sn, input int zf,
                                  input int xs, input int ys, input int r, input int c,
                                  output longint col, output longint row,
                                  output longint fc, output longint fr);
        longint dx, dy, sx, sy;
        dx  = longint'(cs) * c - longint'(sn) * r;
        dy  = longint'(sn) * c + longint'(cs) * r;
        sx  = longint'(xs) * 128 + ((longint'(zf) * dx) >>> 7);
        sy  = longint'(ys) * 128 + ((longint'(zf) * dy) >>> 7);
        col = sx >>> 7;
        row = sy >>> 7;
        fc  = sx & 127;
        fr  = sy & 127;
    endfunction

    // called at a falling edge; returns at the falling edge of the last result
    task automatic run_frame(input int cs, input int sn, input int zf,
                             input int xs, input int ys, input bit disturb);
        rot_cos  = 9'(cs);
        rot_sin  = 9'(sn);
        zoom_inv = 9'(zf);
        crop_x   = 8'(xs);
        crop_y   = 8'(ys);
        start    = 1'b1;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            start = 1'b0;
            chk("R2 latency valid", longint'(valid), 0);
        end
        for (int k = 0; k < NPIX; k++) begin
            longint col, row, fc, fr, tl;
            bit     oor;
            @(negedge clk);
            start = 1'b0;
            model(cs, sn, zf, xs, ys, k / W, k % W, col, row, fc, fr);
            oor = (col < 0) || (row < 0) || (col > W - 2) || (row > H - 2);
            tl  = row * W + col;
            chk("R2 valid", longint'(valid), 1);
            chk("R8 finish", longint'(finish), (k == NPIX - 1) ? 1 : 0);
            chk("R7 out_of_range", longint'(out_of_range), longint'(oor));
            chk("R5 frac_col", longint'(frac_col), fc);
            chk("R5 frac_row", longint'(frac_row), fr);
            if (oor) begin
                chk("R7 addr_tl zero", longint'(addr_tl), 0);
                chk("R7 addr_br zero", longint'(addr_br), 0);
            end else begin
                chk("R6 addr_tl", longint'(addr_tl), tl);
                chk("R6 addr_tr", longint'(addr_tr), tl + 1);
                chk("R6 addr_bl", longint'(addr_bl), tl + W);
                chk("R6 addr_br", longint'(addr_br), tl + W + 1);
            end
            // R3 and R9: garbage parameters and a start mid-scan and mid-drain
            if (disturb && (k == 10 || k == NPIX - 2)) begin
                start    = 1'b1;
                rot_cos  = 9'(-77);
                rot_sin  = 9'(33);
                zoom_inv = 9'(300);
                crop_x   = 8'(3);
                crop_y   = 8'(4);
            end
        end
    endtask

    task automatic idle_check(input int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            chk("R9 no extra valid", longint'(valid), 0);
            chk("R9 no extra finish", longint'(finish), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset valid", longint'(valid), 0);
        chk("R1 reset finish", longint'(finish), 0);
        chk("R1 reset out_of_range", longint'(out_of_range), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset valid", longint'(valid), 0);

        run_frame(128, 0, 128, 0, 0, 1'b0);   // identity
        idle_check(6);
        @(negedge clk);
        run_frame(0, 128, 128, 6, 1, 1'b1);   // 90 deg, disturbed (R3, R9)
        run_frame(64, 111, 32, 2, 1, 1'b0);   // R10 back to back: x4 at 60 deg
        idle_check(3);
        run_frame(114, -58, 128, 1, 2, 1'b0); // 333 deg
        idle_check(2);
        run_frame(-128, 0, 85, 7, 5, 1'b0);   // 180 deg, x1.5
        idle_check(2);
        run_frame(111, 64, 200, 0, 0, 1'b0);  // 30 deg, scale-down
        idle_check(6);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule